// File: doc/BRIEF.md
# PSRAM Low-Power Mode Sequencer

This controller-side block moves a pseudo-static RAM between normal access, plain standby and a low-power state that keeps only part of the array refreshed, or none of it. It owns two memory pins: the active-low chip select and the active-low power-mode pin. In normal operation the chip select follows the access-in-progress input. Standby is simply chip select high with the mode pin high. The low-power state is shown by pulling the mode pin low while chip select stays high.

A low-power request latches a 2-bit hold code at the moment it is accepted. The block then raises chip select, and one cycle later drops the mode pin. A wake request releases the mode pin and starts a down-counter. The counter loads the short guard when a partial hold was chosen and the long guard when the zero-retention hold was chosen. When the count runs out after a partial hold, the block reports ready. After the zero-retention hold it instead asks the surrounding logic for a full power-up initialization. It returns to normal operation once that initialization reports done.

Top module: `psram_lp_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in normal operation with chip select high, mode pin high, ready high and init request low.
- R2: In normal operation chip select goes low on the clock after the access-in-progress input is high, and goes high on the clock after it is low.
- R3: A low-power request is taken only in normal operation with no access in progress. A request made while an access is in progress leaves the mode pin high and the block in normal operation.
- R4: When a request is taken, chip select is high after that clock edge and the mode pin falls on the next edge, so chip select is already high when the mode pin falls. Ready drops on the acceptance edge.
- R5: The hold code is 00 = 16 Mbit, 01 = 8 Mbit, 10 = 4 Mbit and 11 = no retention. It is latched on the acceptance edge, and later changes to the input have no effect on the current low-power period.
- R6: After a 16, 8 or 4 Mbit hold, ready rises exactly PART_EXIT_CYC+1 cycles after the mode pin rises. Chip select stays high until then and for at least one cycle after.
- R7: After the no-retention hold, init request rises exactly ZERO_EXIT_CYC+1 cycles after the mode pin rises. Ready stays low and chip select stays high throughout.
- R8: Init request stays high until init done is seen. The block then returns to normal operation, so ready is high and init request low on the next cycle. Init done in any other state has no effect.
- R9: A wake request that arrives in the cycle right after acceptance is held. The mode pin is then low for exactly one cycle before it rises again.
- R10: Whenever the mode pin is low, chip select is high and ready is low. A wake request in normal operation has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req_i | input | 1 | Request to enter low-power hold |
| hold_sel_i | input | 2 | Retained-density code (see R5) |
| wake_req_i | input | 1 | Request to leave low-power hold |
| busy_i | input | 1 | Access in progress; drives chip select in normal operation |
| init_done_i | input | 1 | Full initialization has finished |
| cs_n_o | output | 1 | Memory chip select, active low |
| mode_n_o | output | 1 | Memory power-mode pin, low = low-power hold |
| ready_o | output | 1 | Memory may be accessed |
| init_req_o | output | 1 | Full power-up initialization required |

## Verification
Two things can land in the same cycle: entry into the hold and a wake request. The bench raises wake in the cycle right after the low-power request is taken. It then checks that the mode pin still falls, stays low for exactly one cycle, and that the exit guard then counts from the mode pin's rise. A second collision puts a low-power request on the same cycle as an access, and checks that the request is refused. Exit timing is judged by counting cycles from the mode pin's rise to ready or init request, and by changing the hold code after acceptance to confirm that the latched value decides the path.

// File: rtl/psram_lp_pkg.sv
package psram_lp_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_ENTER,
        ST_LOWPOWER,
        ST_EXIT_WAIT,
        ST_REINIT_REQ,
        ST_READY
    } lp_state_e;

    // Retained density; only the no-retention code changes behaviour.
    typedef enum logic [1:0] {
        HOLD_16M  = 2'b00,
        HOLD_8M   = 2'b01,
        HOLD_4M   = 2'b10,
        HOLD_NONE = 2'b11
    } hold_sel_e;

endpackage

// File: rtl/psram_exit_timer.sv
module psram_exit_timer #(
    parameter int unsigned PART_EXIT_CYC = 8,
    parameter int unsigned ZERO_EXIT_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic zero_hold_i,
    output logic expired_o
);
    localparam int unsigned MaxCyc = (PART_EXIT_CYC > ZERO_EXIT_CYC) ? PART_EXIT_CYC : ZERO_EXIT_CYC;
    localparam int unsigned CntW   = $clog2(MaxCyc + 1);
    localparam logic [CntW-1:0] PartLd = CntW'(PART_EXIT_CYC);
    localparam logic [CntW-1:0] ZeroLd = CntW'(ZERO_EXIT_CYC);

    logic [CntW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = zero_hold_i ? ZeroLd : PartLd;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/psram_lp_seq.sv
module psram_lp_seq
    import psram_lp_pkg::*;
#(
    parameter int unsigned PART_EXIT_CYC = 8,
    parameter int unsigned ZERO_EXIT_CYC = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_req_i,
    input  logic [1:0] hold_sel_i,
    input  logic       wake_req_i,
    input  logic       busy_i,
    input  logic       init_done_i,
    output logic       cs_n_o,
    output logic       mode_n_o,
    output logic       ready_o,
    output logic       init_req_o
);

    typedef struct packed {
        lp_state_e state;
        hold_sel_e hold;
        logic      wake_pend;
        logic      cs_n;
        logic      mode_n;
    } seq_regs_t;

    localparam seq_regs_t RegsRst = '{
        state:     ST_NORMAL,
        hold:      HOLD_16M,
        wake_pend: 1'b0,
        cs_n:      1'b1,
        mode_n:    1'b1
    };

    seq_regs_t r_d, r_q;
    logic      tmr_load;
    logic      tmr_expired;

    psram_exit_timer #(
        .PART_EXIT_CYC(PART_EXIT_CYC),
        .ZERO_EXIT_CYC(ZERO_EXIT_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .zero_hold_i(r_q.hold == HOLD_NONE),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        unique case (r_q.state)
            ST_NORMAL: begin
                r_d.cs_n = ~busy_i;
                if (lp_req_i && !busy_i) begin
                    r_d.state     = ST_ENTER;
                    r_d.hold      = hold_sel_e'(hold_sel_i);
                    r_d.cs_n      = 1'b1;
                    r_d.wake_pend = 1'b0;
                end
            end
            ST_ENTER: begin
                // chip select went high last edge; mode pin may fall now
                r_d.mode_n = 1'b0;
                r_d.state  = ST_LOWPOWER;
                if (wake_req_i) r_d.wake_pend = 1'b1;
            end
            ST_LOWPOWER: begin
                if (wake_req_i || r_q.wake_pend) begin
                    r_d.mode_n    = 1'b1;
                    r_d.wake_pend = 1'b0;
                    r_d.state     = ST_EXIT_WAIT;
                    tmr_load      = 1'b1;
                end
            end
            ST_EXIT_WAIT: begin
                if (tmr_expired) begin
                    r_d.state = (r_q.hold == HOLD_NONE) ? ST_REINIT_REQ : ST_READY;
                end
            end
            ST_REINIT_REQ: begin
                if (init_done_i) r_d.state = ST_NORMAL;
            end
            ST_READY: begin
                r_d.state = ST_NORMAL;
            end
            default: r_d = RegsRst;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RegsRst;
        else     r_q <= r_d;
    end

    assign cs_n_o     = r_q.cs_n;
    assign mode_n_o   = r_q.mode_n;
    assign ready_o    = (r_q.state == ST_NORMAL) || (r_q.state == ST_READY);
    assign init_req_o = (r_q.state == ST_REINIT_REQ);

endmodule

// File: rtl/psram_lp_seq_chk.sv
module psram_lp_seq_chk #(
    parameter int unsigned PART_EXIT_CYC = 8,
    parameter int unsigned ZERO_EXIT_CYC = 50000
) (
    input logic       clk,
    input logic       rst,
    input logic       lp_req_i,
    input logic [1:0] hold_sel_i,
    input logic       wake_req_i,
    input logic       busy_i,
    input logic       init_done_i,
    input logic       cs_n_o,
    input logic       mode_n_o,
    input logic       ready_o,
    input logic       init_req_o
);
    localparam int unsigned MaxCyc = (PART_EXIT_CYC > ZERO_EXIT_CYC) ? PART_EXIT_CYC : ZERO_EXIT_CYC;
    localparam int unsigned GapW   = $clog2(MaxCyc + 2);
    localparam logic [GapW-1:0] GapSat = GapW'(MaxCyc + 1);

    logic            mode_prev;
    logic [GapW-1:0] gap;

    // cycles elapsed since the mode pin last went high (saturating)
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_prev <= 1'b1;
            gap       <= GapSat;
        end else begin
            mode_prev <= mode_n_o;
            if (mode_n_o && !mode_prev) gap <= '0;
            else if (gap != GapSat)     gap <= gap + 1'b1;
        end
    end

    assert_entry_order_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_n_o) |-> (cs_n_o && $past(cs_n_o)));

    assert_refused_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (lp_req_i && busy_i && mode_n_o) |=> mode_n_o);

    assert_cs_high_in_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !mode_n_o |-> (cs_n_o && !ready_o));

    assert_part_guard_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> (gap >= GapW'(PART_EXIT_CYC)));

    assert_zero_guard_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(init_req_o) |-> (gap >= GapW'(ZERO_EXIT_CYC)));

    assert_init_excl_R7: assert property (@(posedge clk) disable iff (rst)
        init_req_o |-> (!ready_o && cs_n_o && mode_n_o));

    assert_init_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (init_req_o && !init_done_i) |=> init_req_o);

endmodule

bind psram_lp_seq psram_lp_seq_chk #(
    .PART_EXIT_CYC(PART_EXIT_CYC),
    .ZERO_EXIT_CYC(ZERO_EXIT_CYC)
) u_chk (.*);

// File: tb/tb_psram_lp_seq.sv
module tb_psram_lp_seq;

    localparam int unsigned PART = 3;
    localparam int unsigned ZERO = 20;
    localparam int unsigned NVEC = 22;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lp_req_i = 1'b0;
    logic [1:0] hold_sel_i = 2'b00;
    logic       wake_req_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       init_done_i = 1'b0;
    logic       cs_n_o, mode_n_o, ready_o, init_req_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    psram_lp_seq #(.PART_EXIT_CYC(PART), .ZERO_EXIT_CYC(ZERO)) dut (
        .clk(clk), .rst(rst), .lp_req_i(lp_req_i), .hold_sel_i(hold_sel_i),
        .wake_req_i(wake_req_i), .busy_i(busy_i), .init_done_i(init_done_i),
        .cs_n_o(cs_n_o), .mode_n_o(mode_n_o), .ready_o(ready_o), .init_req_o(init_req_o)
    );

    // {lp, wake, busy, hold[1:0], exp cs_n, exp mode_n, exp ready, exp init_req}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_0_1_00_0110,  // 0  R2
        9'b0_0_0_00_1110,  // 1  R2
        9'b1_0_1_00_0110,  // 2  R3 refused while busy
        9'b1_0_0_01_1100,  // 3  R4 accepted, 8 Mbit
        9'b0_0_0_11_1000,  // 4  R10 code changed after entry
        9'b0_0_0_11_1000,  // 5  R10
        9'b0_1_0_11_1100,  // 6  R6 wake
        9'b0_0_0_11_1100,  // 7  R6
        9'b0_0_0_11_1100,  // 8  R6
        9'b0_0_0_11_1100,  // 9  R6
        9'b0_0_0_11_1110,  // 10 R5 latched code chose short path
        9'b0_0_1_00_1110,  // 11 R6 cs held through ready cycle
        9'b0_0_1_00_0110,  // 12 R2
        9'b0_0_0_00_1110,  // 13 R2
        9'b1_0_0_00_1100,  // 14 R4
        9'b0_1_0_00_1000,  // 15 R9 wake during entry
        9'b0_0_0_00_1100,  // 16 R9 mode low for one cycle
        9'b0_0_0_00_1100,  // 17 R6
        9'b0_0_0_00_1100,  // 18 R6
        9'b0_0_0_00_1100,  // 19 R6
        9'b0_0_0_00_1110,  // 20 R6
        9'b0_1_0_00_1110   // 21 R10 wake ignored in normal
    };

    function automatic string row_tag(int i);
        case (i)
            0, 1, 12, 13:               return "R2";
            2:                          return "R3";
            3, 14:                      return "R4";
            4, 5, 21:                   return "R10";
            10:                         return "R5";
            15, 16:                     return "R9";
            default:                    return "R6";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [3:0] exp);
        logic [3:0] act;
        act = {cs_n_o, mode_n_o, ready_o, init_req_o};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {cs_n,mode_n,ready,init_req} actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        logic cs_dropped;
        logic rdy_seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 4'b1110);

        for (int i = 0; i < NVEC; i++) begin
            {lp_req_i, wake_req_i, busy_i, hold_sel_i} = VEC[i][8:4];
            step();
            check($sformatf("%s vector %0d", row_tag(i), i), VEC[i][3:0]);
        end
        {lp_req_i, wake_req_i, busy_i, hold_sel_i} = 5'b0;

        // R8: init done outside reinit has no effect
        init_done_i = 1'b1;
        step();
        init_done_i = 1'b0;
        check("R8 stray init done", 4'b1110);

        // R7/R5: no-retention hold; code changed after acceptance must not matter
        lp_req_i = 1'b1; hold_sel_i = 2'b11;
        step();
        lp_req_i = 1'b0; hold_sel_i = 2'b00;
        step();
        check("R4 zero-hold entry", 4'b1000);
        wake_req_i = 1'b1;
        step();
        wake_req_i = 1'b0;
        check("R7 mode released", 4'b1100);
        cyc = 0;
        cs_dropped = 1'b0;
        rdy_seen = 1'b0;
        while (!init_req_o && cyc < 200) begin
            step();
            cyc++;
            if (!cs_n_o) cs_dropped = 1'b1;
            if (ready_o) rdy_seen = 1'b1;
        end
        n_chk++;
        if (cyc != int'(ZERO + 1)) begin
            n_fail++;
            $display("FAIL R7: init request delay actual %0d expected %0d", cyc, ZERO + 1);
        end
        check("R5 latched no-retention code", 4'b1101);
        check("R7 cs high, ready low during guard", {~cs_dropped, 1'b1, rdy_seen, 1'b1});

        repeat (3) step();
        check("R8 request held without done", 4'b1101);
        init_done_i = 1'b1;
        step();
        init_done_i = 1'b0;
        check("R8 back to normal", 4'b1110);

        // R1: reset during hold releases the mode pin
        lp_req_i = 1'b1; hold_sel_i = 2'b10;
        step();
        lp_req_i = 1'b0;
        step();
        check("R10 in hold", 4'b1000);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 reset from hold", 4'b1110);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule